// File: doc/BRIEF.md
# Two-Bank Sequenced Bidirectional Shifter

This block holds one data word in a working bank and shifts it one position left or right. The shift does not use direct wiring between neighbouring bits inside one clock. Every shift instead runs as a fixed four-step transfer through a second, holding bank. First the working word is copied up into the holding bank, which is empty at that point. Next the working bank is cleared. Then the holding word is copied back down, displaced by one position. Last the holding bank is cleared so that it is ready for the next shift.

The caller starts a shift with a single-cycle request. At that moment it also gives the direction and a fill bit, which enters the bit position left empty by the shift. The block reports `busy` for the four steps and pulses `done` in the last step. The bit that drops off the end of the word appears on `serial_out` while the copy-down step is running. The working bank can be loaded in parallel while the block is idle, so that any start value can be set. All ports are plain control and status pins. No stream data passes through the block, so it has no valid/ready handshake and applies no back-pressure.

Top module: `bidir_xfer_shifter`

## Requirements
- R1: When `rst` is high at a clock edge, the next state has `work_q` equal to 0, `busy` equal to 0, `done` equal to 0 and `serial_out` equal to 0.
- R2: When `load_en` is high and `busy` is low at an edge, `work_q` equals `load_data` after that edge. If `shift_req` is high in the same cycle, the load wins and no shift starts.
- R3: A `load_en` that arrives while `busy` is high has no effect on `work_q`.
- R4: A `shift_req` seen while idle raises `busy` after that edge. `busy` then stays high for exactly four cycles. During the first of these cycles, `work_q` still shows the old word.
- R5: During the third busy cycle (the copy-down step), `work_q` reads all zeros.
- R6: When `shift_dir` is 0 (right) at the request, the new word is `old >> 1`, and `fill_in` enters at the most significant bit.
- R7: When `shift_dir` is 1 (left) at the request, the new word is `(old << 1)` cut to WIDTH bits, and `fill_in` enters at bit 0.
- R8: During the copy-down step, `serial_out` carries the bit that leaves the word: old bit 0 for a right shift, old bit WIDTH-1 for a left shift. At all other times it is 0.
- R9: `done` is high only in the fourth busy cycle, for exactly one cycle. The holding bank is zero whenever `busy` is low.
- R10: A `shift_req` that arrives while `busy` is high is ignored. After `done`, the block returns to idle, and exactly one shift has been applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| shift_req | input | 1 | Start a one-position shift (taken only while idle) |
| shift_dir | input | 1 | 1 = left, 0 = right; sampled with the request |
| fill_in | input | 1 | Bit entering the vacated position; sampled with the request |
| load_en | input | 1 | Parallel load of the working bank (taken only while idle) |
| load_data | input | WIDTH | Word for parallel load |
| work_q | output | WIDTH | Working bank contents |
| busy | output | 1 | Shift sequence in progress |
| done | output | 1 | One-cycle pulse in the holding-clear step |
| serial_out | output | 1 | Bit shifted out, valid during the copy-down step |

## Verification
The hardest case to reach from the ports is a request or a load that collides with a sequence already in flight. The intermediate cleared word in the copy-down step is just as hard to catch. The bench loads every 4-bit word and shifts it both ways with both fill values. In a subset of these runs it holds `shift_req` and `load_en` high, with a different word, through every busy cycle. It checks `work_q` and `serial_out` step by step, then confirms that exactly one shift landed and that the block went idle.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
  typedef enum logic [2:0] {
    PH_IDLE      = 3'd0,
    PH_COPY_UP   = 3'd1,
    PH_CLR_WORK  = 3'd2,
    PH_COPY_DOWN = 3'd3,
    PH_CLR_HOLD  = 3'd4
  } phase_t;
endpackage

// File: rtl/xfer_word_bank.sv
module xfer_word_bank #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             ld,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst || clr) q <= '0;
    else if (ld)    q <= d;
  end
endmodule

// File: rtl/xfer_shift_net.sv
module xfer_shift_net #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] src,
  input  logic             dir_left,
  input  logic             fill,
  output logic [WIDTH-1:0] displaced,
  output logic             lost_bit
);
  localparam int MSB = WIDTH - 1;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic from_right_neighbour;
    logic from_left_neighbour;
    if (i == 0) begin : g_lsb
      assign from_right_neighbour = fill;
    end else begin : g_lo
      assign from_right_neighbour = src[i-1];
    end
    if (i == MSB) begin : g_msb
      assign from_left_neighbour = fill;
    end else begin : g_hi
      assign from_left_neighbour = src[i+1];
    end
    assign displaced[i] = dir_left ? from_right_neighbour : from_left_neighbour;
  end

  assign lost_bit = dir_left ? src[MSB] : src[0];
endmodule

// File: rtl/xfer_sequencer.sv
module xfer_sequencer (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  output xfer_pkg::phase_t phase,
  output logic            busy,
  output logic            done
);
  import xfer_pkg::*;

  phase_t nxt;

  always_comb begin
    unique case (phase)
      PH_IDLE:      nxt = start ? PH_COPY_UP : PH_IDLE;
      PH_COPY_UP:   nxt = PH_CLR_WORK;
      PH_CLR_WORK:  nxt = PH_COPY_DOWN;
      PH_COPY_DOWN: nxt = PH_CLR_HOLD;
      PH_CLR_HOLD:  nxt = PH_IDLE;
      default:      nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) phase <= PH_IDLE;
    else     phase <= nxt;
  end

  assign busy = (phase != PH_IDLE);
  assign done = (phase == PH_CLR_HOLD);
endmodule

// File: rtl/bidir_xfer_shifter.sv
module bidir_xfer_shifter #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift_req,
  input  logic             shift_dir,
  input  logic             fill_in,
  input  logic             load_en,
  input  logic [WIDTH-1:0] load_data,
  output logic [WIDTH-1:0] work_q,
  output logic             busy,
  output logic             done,
  output logic             serial_out
);
  import xfer_pkg::*;

  phase_t           phase;
  logic             idle;
  logic             accept_load;
  logic             accept_shift;
  logic             cmd_left;
  logic             cmd_fill;
  logic [WIDTH-1:0] hold_q;
  logic [WIDTH-1:0] displaced;
  logic             lost_bit;
  logic [WIDTH-1:0] work_d;

  assign idle         = !busy;
  assign accept_load  = idle && load_en;
  assign accept_shift = idle && shift_req && !load_en;

  xfer_sequencer u_seq (
    .clk   (clk),
    .rst   (rst),
    .start (accept_shift),
    .phase (phase),
    .busy  (busy),
    .done  (done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_left <= 1'b0;
      cmd_fill <= 1'b0;
    end else if (accept_shift) begin
      cmd_left <= shift_dir;
      cmd_fill <= fill_in;
    end
  end

  xfer_shift_net #(.WIDTH(WIDTH)) u_net (
    .src       (hold_q),
    .dir_left  (cmd_left),
    .fill      (cmd_fill),
    .displaced (displaced),
    .lost_bit  (lost_bit)
  );

  assign work_d = (phase == PH_COPY_DOWN) ? displaced : load_data;

  xfer_word_bank #(.WIDTH(WIDTH)) u_work (
    .clk (clk),
    .rst (rst),
    .clr (phase == PH_CLR_WORK),
    .ld  (accept_load || (phase == PH_COPY_DOWN)),
    .d   (work_d),
    .q   (work_q)
  );

  xfer_word_bank #(.WIDTH(WIDTH)) u_hold (
    .clk (clk),
    .rst (rst),
    .clr (phase == PH_CLR_HOLD),
    .ld  (phase == PH_COPY_UP),
    .d   (work_q),
    .q   (hold_q)
  );

  assign serial_out = (phase == PH_COPY_DOWN) && lost_bit;
endmodule

// File: rtl/xfer_shifter_checker.sv
module xfer_shifter_checker #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             busy,
  input logic             done,
  input logic             load_en,
  input logic [WIDTH-1:0] load_data,
  input logic [WIDTH-1:0] work_q,
  input logic [WIDTH-1:0] hold_q,
  input logic             serial_out
);
  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst) $past(rst) |-> (!busy && !done && work_q == '0)); // R1
  AST_LOAD_IDLE: assert property (@(posedge clk) disable iff (rst) (!$past(rst) && $past(load_en && !busy)) |-> (work_q == $past(load_data))); // R2
  AST_BUSY_LEN: assert property (@(posedge clk) disable iff (rst) $rose(busy) |=> busy ##1 busy ##1 busy ##1 !busy); // R4
  AST_MID_CLEAR: assert property (@(posedge clk) disable iff (rst) $rose(busy) |=> ##1 (work_q == '0)); // R5
  AST_SOUT_QUIET: assert property (@(posedge clk) disable iff (rst) (!busy || done) |-> !serial_out); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R9
  AST_HOLD_EMPTY: assert property (@(posedge clk) disable iff (rst) !busy |-> (hold_q == '0)); // R9
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (rst) done |=> !busy); // R10
endmodule

bind bidir_xfer_shifter xfer_shifter_checker #(.WIDTH(WIDTH)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .busy       (busy),
  .done       (done),
  .load_en    (load_en),
  .load_data  (load_data),
  .work_q     (work_q),
  .hold_q     (hold_q),
  .serial_out (serial_out)
);

// File: tb/bidir_xfer_shifter_bench.sv
`timescale 1ns/1ps
module bidir_xfer_shifter_bench;
  localparam int W = 4;
  localparam logic [W-1:0] MASK = '1;

  logic         clk = 1'b0;
  logic         rst;
  logic         shift_req, shift_dir, fill_in, load_en;
  logic [W-1:0] load_data;
  logic [W-1:0] work_q;
  logic         busy, done, serial_out;
  int           checks = 0;
  int           errors = 0;
  bit           finished = 1'b0;

  always #2.5 clk = ~clk;

  bidir_xfer_shifter #(.WIDTH(W)) u_bidir_xfer_shifter (
    .clk(clk), .rst(rst), .shift_req(shift_req), .shift_dir(shift_dir),
    .fill_in(fill_in), .load_en(load_en), .load_data(load_data),
    .work_q(work_q), .busy(busy), .done(done), .serial_out(serial_out)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run_shift(input logic [W-1:0] v, input bit left, input bit fill, input bit noisy);
    logic [W-1:0] exp_word;
    bit           exp_out;
    exp_word = left ? (((v << 1) | W'(fill)) & MASK) : ((v >> 1) | (W'(fill) << (W-1)));
    exp_out  = left ? v[W-1] : v[0];
    load_en = 1'b1; load_data = v;
    step();
    chk(work_q == v, "R2 idle load", work_q, v);
    load_en = 1'b0; shift_req = 1'b1; shift_dir = left; fill_in = fill;
    step();
    chk(busy == 1'b1, "R4 busy rises", busy, 1);
    chk(work_q == v, "R4 word held in copy-up", work_q, v);
    shift_req = noisy; load_en = noisy; load_data = ~v;
    shift_dir = ~left; fill_in = ~fill;
    step();
    chk(work_q == v, "R3 load ignored while busy", work_q, v);
    chk(serial_out == 1'b0, "R8 quiet before copy-down", serial_out, 0);
    step();
    chk(work_q == '0, "R5 working bank cleared", work_q, 0);
    chk(serial_out == exp_out, "R8 lost bit", serial_out, exp_out);
    chk(done == 1'b0, "R9 no early done", done, 0);
    step();
    if (left) chk(work_q == exp_word, "R7 left result", work_q, exp_word);
    else      chk(work_q == exp_word, "R6 right result", work_q, exp_word);
    chk(done == 1'b1 && busy == 1'b1, "R9 done in fourth cycle", done, 1);
    chk(serial_out == 1'b0, "R8 quiet after copy-down", serial_out, 0);
    shift_req = 1'b0; load_en = 1'b0;
    step();
    chk(busy == 1'b0 && done == 1'b0, "R10 idle after done", busy, 0);
    step();
    chk(work_q == exp_word && !busy, "R10 single shift applied", work_q, exp_word);
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; shift_req = 1'b0; shift_dir = 1'b0; fill_in = 1'b0;
    load_en = 1'b0; load_data = '0;
    @(negedge clk);
    step();
    rst = 1'b0;
    chk(work_q == '0, "R1 reset word", work_q, 0);
    chk(!busy && !done && !serial_out, "R1 reset flags", busy, 0);

    // R2: load and request together, load wins
    load_en = 1'b1; load_data = 4'hA; shift_req = 1'b1;
    step();
    load_en = 1'b0; shift_req = 1'b0;
    chk(work_q == 4'hA, "R2 load priority word", work_q, 4'hA);
    chk(busy == 1'b0, "R2 no shift started", busy, 0);

    for (int v = 0; v < (1 << W); v++) begin
      for (int d = 0; d < 2; d++) begin
        for (int f = 0; f < 2; f++) begin
          run_shift(W'(v), d[0], f[0], ((v + d + f) % 2) == 1);
        end
      end
    end

    // reset in mid-sequence
    load_en = 1'b1; load_data = 4'h5;
    step();
    load_en = 1'b0; shift_req = 1'b1;
    step();
    shift_req = 1'b0;
    rst = 1'b1;
    step();
    rst = 1'b0;
    chk(work_q == '0 && !busy, "R1 reset mid-shift", work_q, 0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule